// File: doc/BRIEF.md
# Bidirectional Shift Register with Mode-Selected Fill

This block is a 16-bit register built from two cascaded 8-bit stages. On each rising clock edge it either loads a parallel word, shifts one place left or right, or keeps its value. When it shifts, one bit position at an end of the word is emptied. A small fill selector picks the bit that goes into that position. The choice depends on two mode lines and the shift direction.

The four fill behaviours are as follows. Rotate puts the bit that was shifted out back in at the opposite end. Carry-fill inserts an external carry bit. Zero-fill inserts 0. The fourth behaviour depends on direction: an arithmetic right shift copies the sign bit, and a left shift inserts 0. The surrounding datapath drives the mode lines, the direction, the carry and the load word. It reads all bits of the register in parallel.

Top module: `xmit_shifter`

## Requirements
- R1: While rst_ni is low, data_o is all zeros. The clear is asynchronous and does not wait for a clock edge.
- R2: When load_i is 1 at a rising edge, data_o takes load_data_i at that edge, whatever shift_i holds.
- R3: When load_i and shift_i are both 0 at a rising edge, data_o keeps its value.
- R4: A right shift (load_i=0, shift_i=1, dir_left_i=0) moves every bit n to bit n-1, crossing the boundary between the stages from bit 8 to bit 7. The fill bit enters bit 15.
- R5: A left shift (load_i=0, shift_i=1, dir_left_i=1) moves every bit n to bit n+1, crossing the boundary between the stages from bit 7 to bit 8. The fill bit enters bit 0.
- R6: With mode_b_i=1 and mode_a_i=1 the word rotates. A right shift puts the old bit 0 into bit 15, and a left shift puts the old bit 15 into bit 0.
- R7: With mode_b_i=0 and mode_a_i=1, the vacated bit takes carry_i in either direction.
- R8: With mode_b_i=1 and mode_a_i=0, the vacated bit becomes 0 in either direction.
- R9: With mode_b_i=0 and mode_a_i=0, a right shift copies the old bit 15 into bit 15 (an arithmetic shift), and a left shift puts 0 into bit 0.
- R10: dir_left_i is sampled at the shift edge: 1 selects a left shift and 0 selects a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; the register acts on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the register |
| load_i | input | 1 | Parallel load request; has priority over shift_i |
| load_data_i | input | 16 | Parallel load word |
| shift_i | input | 1 | Shift request for one place |
| dir_left_i | input | 1 | Shift direction: 1 for left, 0 for right |
| mode_a_i | input | 1 | Fill mode select, low bit |
| mode_b_i | input | 1 | Fill mode select, high bit |
| carry_i | input | 1 | Carry bit used by carry-fill |
| data_o | output | 16 | Register contents |

## Verification
The bench builds the block with the default parameters: two stages of eight bits, giving a 16-bit word. This makes the single boundary between the stages visible. A lone bit is walked across that boundary in both directions, and a word is rotated all the way round to confirm it comes back unchanged. Each of the four fill modes is tried in both directions, with a sign bit of 1 and of 0 and with a carry of 1 and of 0. The bench also checks that a load wins over a shift, and that reset clears the register with no clock edge in between.

// File: rtl/xmit_shifter_pkg.sv
package xmit_shifter_pkg;
  // Encoding is {mode_b, mode_a}
  typedef enum logic [1:0] {
    FILL_ARITH = 2'b00,
    FILL_CARRY = 2'b01,
    FILL_ZERO  = 2'b10,
    FILL_ROT   = 2'b11
  } fill_mode_e;
endpackage

// File: rtl/fill_select.sv
module fill_select
  import xmit_shifter_pkg::*;
(
  input  fill_mode_e mode_i,
  input  logic       dir_left_i,
  input  logic       carry_i,
  input  logic       msb_i,
  input  logic       lsb_i,
  output logic       fill_o
);
  always_comb begin
    unique case (mode_i)
      FILL_ROT:   fill_o = dir_left_i ? msb_i : lsb_i;
      FILL_CARRY: fill_o = carry_i;
      FILL_ZERO:  fill_o = 1'b0;
      default:    fill_o = dir_left_i ? 1'b0 : msb_i;
    endcase
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int STAGE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STAGE_W-1:0] load_data_i,
  input  logic               shift_i,
  input  logic               dir_left_i,
  input  logic               ser_top_i,  // enters msb on right shift
  input  logic               ser_bot_i,  // enters lsb on left shift
  output logic [STAGE_W-1:0] q_o
);
  logic [STAGE_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (load_i)          q_d = load_data_i;
    else if (shift_i) begin
      if (dir_left_i)    q_d = {q_o[STAGE_W-2:0], ser_bot_i};
      else               q_d = {ser_top_i, q_o[STAGE_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  assert_stage_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(q_o));
endmodule

// File: rtl/xmit_shifter.sv
module xmit_shifter
  import xmit_shifter_pkg::*;
#(
  parameter  int STAGE_W    = 8,
  parameter  int NUM_STAGES = 2,
  localparam int WIDTH      = STAGE_W * NUM_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             shift_i,
  input  logic             dir_left_i,
  input  logic             mode_a_i,
  input  logic             mode_b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] data_o
);
  fill_mode_e mode;
  logic       fill;
  logic [NUM_STAGES-1:0][STAGE_W-1:0] stage_q;

  assign mode = fill_mode_e'({mode_b_i, mode_a_i});

  fill_select u_fill (
    .mode_i     (mode),
    .dir_left_i (dir_left_i),
    .carry_i    (carry_i),
    .msb_i      (data_o[WIDTH-1]),
    .lsb_i      (data_o[0]),
    .fill_o     (fill)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic ser_top, ser_bot;
    if (s == NUM_STAGES - 1) begin : g_top
      assign ser_top = fill;
    end else begin : g_mid_top
      assign ser_top = stage_q[s+1][0];
    end
    if (s == 0) begin : g_bot
      assign ser_bot = fill;
    end else begin : g_mid_bot
      assign ser_bot = stage_q[s-1][STAGE_W-1];
    end

    shift_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_i),
      .load_data_i (load_data_i[s*STAGE_W +: STAGE_W]),
      .shift_i     (shift_i),
      .dir_left_i  (dir_left_i),
      .ser_top_i   (ser_top),
      .ser_bot_i   (ser_bot),
      .q_o         (stage_q[s])
    );
  end

  assign data_o = stage_q;

  logic do_shift;
  assign do_shift = shift_i && !load_i;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> data_o == $past(load_data_i));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(data_o));
  assert_rshift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && !dir_left_i) |=> data_o[WIDTH-2:0] == $past(data_o[WIDTH-1:1]));
  assert_lshift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && dir_left_i) |=> data_o[WIDTH-1:1] == $past(data_o[WIDTH-2:0]));
  assert_rot_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && !dir_left_i && mode_a_i && mode_b_i) |=> data_o[WIDTH-1] == $past(data_o[0]));
  assert_rot_left_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && dir_left_i && mode_a_i && mode_b_i) |=> data_o[0] == $past(data_o[WIDTH-1]));
  assert_carry_right_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && !dir_left_i && mode_a_i && !mode_b_i) |=> data_o[WIDTH-1] == $past(carry_i));
  assert_carry_left_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && dir_left_i && mode_a_i && !mode_b_i) |=> data_o[0] == $past(carry_i));
  assert_zero_right_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && !dir_left_i && !mode_a_i && mode_b_i) |=> !data_o[WIDTH-1]);
  assert_zero_left_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && dir_left_i && !mode_a_i && mode_b_i) |=> !data_o[0]);
  assert_sign_right_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && !dir_left_i && !mode_a_i && !mode_b_i) |=> $stable(data_o[WIDTH-1]));
  assert_zero_left_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_shift && dir_left_i && !mode_a_i && !mode_b_i) |=> !data_o[0]);
endmodule

// File: tb/xmit_shifter_tb_top.sv
module xmit_shifter_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] load_data_i = '0;
  logic         shift_i = 1'b0;
  logic         dir_left_i = 1'b0;
  logic         mode_a_i = 1'b0;
  logic         mode_b_i = 1'b0;
  logic         carry_i = 1'b0;
  logic [W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t sb_q[$];
  logic [W-1:0] model = '0;

  always #5 clk_i = ~clk_i;

  xmit_shifter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_data_i(load_data_i),
    .shift_i(shift_i), .dir_left_i(dir_left_i), .mode_a_i(mode_a_i),
    .mode_b_i(mode_b_i), .carry_i(carry_i), .data_o(data_o)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic fill_bit(input logic [W-1:0] m, input logic left,
                                    input logic mb, input logic ma, input logic c);
    case ({mb, ma})
      2'b11:   return left ? m[W-1] : m[0];   // R6
      2'b01:   return c;                      // R7
      2'b10:   return 1'b0;                   // R8
      default: return left ? 1'b0 : m[W-1];   // R9
    endcase
  endfunction

  // Driver: one cycle of stimulus, expected result queued for the monitor
  task automatic drive(input logic ld, input logic [W-1:0] d, input logic sh,
                       input logic left, input logic mb, input logic ma,
                       input logic c, input string req);
    item_t it;
    @(negedge clk_i);
    load_i = ld; load_data_i = d; shift_i = sh; dir_left_i = left;
    mode_b_i = mb; mode_a_i = ma; carry_i = c;
    if (ld) model = d;
    else if (sh) begin
      if (left) model = {model[W-2:0], fill_bit(model, left, mb, ma, c)};
      else      model = {fill_bit(model, left, mb, ma, c), model[W-1:1]};
    end
    it.exp = model;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(data_o, it.exp, it.req);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(data_o, '0, "R1 reset value");
    rst_ni = 1'b1;

    drive(1, 16'h8001, 0, 0, 0, 0, 0, "R2 load");
    drive(0, '0, 1, 0, 1, 1, 0, "R6 rotate right");      // C000
    drive(0, '0, 1, 1, 1, 1, 0, "R6 rotate left");       // 8001
    drive(0, '0, 1, 1, 1, 1, 0, "R6 rotate left wrap");  // 0003
    for (int i = 0; i < 16; i++) drive(0, '0, 1, 0, 1, 1, 0, "R6 full rotation");
    drive(1, 16'hA5C3, 1, 1, 0, 1, 1, "R2 load beats shift");
    drive(0, 16'hFFFF, 0, 1, 0, 1, 1, "R3 hold");
    drive(0, '0, 1, 0, 0, 1, 1, "R7 carry right c=1");
    drive(0, '0, 1, 0, 0, 1, 0, "R7 carry right c=0");
    drive(0, '0, 1, 1, 0, 1, 1, "R7 carry left c=1");
    drive(0, '0, 1, 1, 0, 1, 0, "R7 carry left c=0");
    drive(1, 16'hFFFF, 0, 0, 0, 0, 0, "R2 load ones");
    drive(0, '0, 1, 0, 1, 0, 1, "R8 zero right");
    drive(0, '0, 1, 1, 1, 0, 1, "R8 zero left");
    drive(1, 16'h8F00, 0, 0, 0, 0, 0, "R2 load neg");
    drive(0, '0, 1, 0, 0, 0, 1, "R9 sign right msb=1");
    drive(0, '0, 1, 0, 0, 0, 1, "R9 sign right again");
    drive(0, '0, 1, 1, 0, 0, 1, "R9 zero left");
    drive(1, 16'h4000, 0, 0, 0, 0, 0, "R2 load pos");
    drive(0, '0, 1, 0, 0, 0, 1, "R9 sign right msb=0");
    drive(1, 16'h0100, 0, 0, 0, 0, 0, "R2 load bit8");
    drive(0, '0, 1, 0, 1, 0, 0, "R4 cross stage right");  // 0080
    drive(0, '0, 1, 1, 1, 0, 0, "R5 cross stage left");   // 0100
    drive(0, '0, 1, 1, 1, 0, 0, "R10/R5 left select");    // 0200
    drive(0, '0, 1, 0, 1, 0, 0, "R10/R4 right select");   // 0100
    drive(0, '0, 0, 0, 0, 0, 0, "R3 idle");
    for (int i = 0; i < 8; i++) drive(0, '0, 1, 1, 0, 1, i[0], "R5 left carry walk");
    for (int i = 0; i < 8; i++) drive(0, '0, 1, 0, 0, 1, i[1], "R4 right carry walk");
    drive(0, '0, 0, 0, 0, 0, 0, "R3 idle end");
    repeat (2) @(negedge clk_i);

    // async clear mid-cycle
    drive(1, 16'h1234, 0, 0, 0, 0, 0, "R2 load pre-reset");
    repeat (2) @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check(data_o, '0, "R1 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule